// File: doc/BRIEF.md
# Converter Result Store with Overrun Guard

This block sits between an analog-to-digital converter core and the register and DMA fabric of a chip. Each finished conversion arrives as one tagged beat: a raw code, a flag choosing the regular or the injected group, a slot index for the injected group and a channel number. Regular results go to a single holding register. Injected results go to one of four slot registers, and each slot can subtract its own offset from the raw code. All stored words are trimmed to the selected resolution and placed right- or left-justified in a 16-bit word.

There is only one regular holding register. A multi-channel regular scan therefore relies on DMA to drain every result before the next one lands. The block raises a DMA request while a regular result is waiting and withdraws it when the result is taken. If a new regular result arrives before the old one has been taken, a sticky overrun flag is set. With DMA enabled, the new result is dropped, a one-cycle abort is sent to the sequencer and DMA stays halted until the flag is cleared. With DMA disabled, the new result simply overwrites the old one.

Top module: `adc_result_store`

## Requirements
- R1: After reset, reg_valid_o, inj_valid_o, ovr_o, dma_req_o and abort_o are 0, and reg_data_o is 0.
- R2: A beat with res_valid_i=1 and res_inj_i=0 stores the formatted result in reg_data_o and the channel tag in reg_chan_o, and sets reg_valid_o, all visible in the cycle after the beat.
- R3: cfg_res_i selects the resolution k: 0 gives 12 bits, 1 gives 10, 2 gives 8 and 3 gives 6. Raw input bits at or above k are ignored.
- R4: With cfg_left_i=0 an unsigned result is zero-extended in bits [k-1:0]. With cfg_left_i=1 it occupies bits [15:16-k] and the lower bits are 0.
- R5: A reg_rd_i or dma_ack_i pulse clears reg_valid_o and drops dma_req_o in the next cycle. If a new regular beat arrives in the same cycle as the read, it is stored with reg_valid_o=1 and no overrun.
- R6: dma_req_o is high while a regular result is waiting, cfg_dma_en_i=1 and DMA is not halted.
- R7: A regular beat that arrives while reg_valid_o=1 with no read or acknowledge in the same cycle sets ovr_o in the next cycle. With cfg_dma_en_i=0 the new result replaces the stored one.
- R8: If that overrun happens with cfg_dma_en_i=1, the new result is discarded, abort_o pulses for exactly one cycle and dma_req_o goes low. Later regular beats are ignored until ovr_clr_i is pulsed, after which a result still waiting raises dma_req_o again.
- R9: ovr_o stays set until ovr_clr_i is pulsed. A new overrun in the same cycle as the clear keeps it set.
- R10: An injected beat (res_inj_i=1) writes slot res_idx_i and sets bit res_idx_i of inj_valid_o. Pulsing bit j of inj_rd_i clears bit j. An injected beat never touches the regular register or ovr_o.
- R11: When ofs_en_i[j]=1, slot j stores raw minus ofs_val_i[j] (both trimmed to k bits) as a two's-complement value. Right-justified, the value is sign-extended to 16 bits.
- R12: Left-justified, a slot with its offset enabled holds the (k+1)-bit signed difference with its sign in bit 15 (shifted left by 15-k). A slot with its offset disabled is formatted as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | Conversion result beat |
| res_inj_i | input | 1 | Beat belongs to the injected group |
| res_idx_i | input | 2 | Injected slot index |
| res_chan_i | input | 5 | Channel tag of the beat |
| res_data_i | input | 12 | Raw conversion code |
| cfg_res_i | input | 2 | Resolution code |
| cfg_left_i | input | 1 | Left-justify results |
| cfg_dma_en_i | input | 1 | DMA draining of the regular register |
| ofs_en_i | input | 4 | Per-slot offset enable |
| ofs_val_i | input | 48 | Per-slot offsets, slot j in bits [12j+11:12j] |
| reg_rd_i | input | 1 | Read strobe of the regular register |
| dma_ack_i | input | 1 | DMA transfer of the regular register done |
| ovr_clr_i | input | 1 | Clear overrun and DMA halt |
| inj_rd_i | input | 4 | Read strobe per injected slot |
| reg_data_o | output | 16 | Regular result word |
| reg_chan_o | output | 5 | Channel tag of the regular result |
| reg_valid_o | output | 1 | Regular result waiting |
| dma_req_o | output | 1 | DMA request |
| ovr_o | output | 1 | Sticky overrun flag |
| abort_o | output | 1 | One-cycle sequence abort |
| inj_data_o | output | 64 | Slot results, slot j in bits [16j+15:16j] |
| inj_valid_o | output | 4 | Per-slot result waiting |

## Verification
The hardest state to reach is the DMA halt. The stimulus has to leave a regular result unacknowledged while DMA is enabled, then land a second regular beat. After that it must show that a third beat is ignored, that the first result is still held and that the request comes back only after the clear. The sequence drives exactly this chain, and it also applies the clear in the same cycle as a fresh collision. The signed left-justified path is reached by choosing raw codes below their offset at the 12-bit and 6-bit resolutions. One case uses an offset whose set bits all lie above the active resolution, so trimming leaves nothing to subtract.

// File: rtl/adc_rs_pkg.sv
package adc_rs_pkg;
  // resolution code: 0=full, each step drops two bits
  typedef logic [1:0] res_code_t;

  function automatic logic [5:0] res_bits(input res_code_t code, input int unsigned full);
    return 6'(full) - {3'b000, code, 1'b0};
  endfunction
endpackage

// File: rtl/adc_rs_fmt.sv
module adc_rs_fmt
  import adc_rs_pkg::*;
#(
  parameter int RAW_W = 12,
  parameter int OUT_W = 16
) (
  input  logic [RAW_W-1:0] raw_i,
  input  logic [RAW_W-1:0] ofs_i,
  input  res_code_t        res_i,
  input  logic             left_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int DIFF_W = RAW_W + 1;

  logic [5:0]        bits, shamt;
  logic [RAW_W-1:0]  mask, v, o;
  logic [DIFF_W-1:0] diff;
  logic [OUT_W-1:0]  wide;

  always_comb begin
    bits = res_bits(res_i, RAW_W);
    mask = ~({RAW_W{1'b1}} << bits);
    v    = raw_i & mask;
    o    = ofs_i & mask;
    diff = {1'b0, v} - {1'b0, o};
    if (signed_i) begin
      wide  = {{(OUT_W-DIFF_W){diff[DIFF_W-1]}}, diff};
      shamt = 6'(OUT_W - 1) - bits;
    end else begin
      wide  = {{(OUT_W-RAW_W){1'b0}}, v};
      shamt = 6'(OUT_W) - bits;
    end
    data_o = left_i ? (wide << shamt) : wide;
  end
endmodule

// File: rtl/adc_rs_inj_slot.sv
module adc_rs_inj_slot #(
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [OUT_W-1:0] data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (wr_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (rd_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  // R10: write marks the slot, a lone read empties it, no write keeps data
  a_r10_wr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o);
  a_r10_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> !valid_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(data_o));
endmodule

// File: rtl/adc_rs_regular.sv
module adc_rs_regular #(
  parameter int OUT_W  = 16,
  parameter int CHAN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OUT_W-1:0]  data_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              rd_i,
  input  logic              ack_i,
  input  logic              dma_en_i,
  input  logic              ovr_clr_i,
  output logic [OUT_W-1:0]  data_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              valid_o,
  output logic              dma_req_o,
  output logic              ovr_o,
  output logic              abort_o
);
  logic halt_q;
  logic take, accept, collide, drop, store;

  always_comb begin
    take    = rd_i | ack_i;
    accept  = wr_i & ~halt_q;
    collide = accept & valid_o & ~take;
    drop    = collide & dma_en_i;
    store   = accept & ~drop;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      chan_o  <= '0;
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
      halt_q  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      if (store) begin
        data_o  <= data_i;
        chan_o  <= chan_i;
        valid_o <= 1'b1;
      end else if (take) begin
        valid_o <= 1'b0;
      end
      // set beats clear
      ovr_o   <= collide | (ovr_o & ~ovr_clr_i);
      halt_q  <= drop | (halt_q & ~ovr_clr_i);
      abort_o <= drop;
    end
  end

  assign dma_req_o = valid_o & dma_en_i & ~halt_q;

  a_r5_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !wr_i) |=> !valid_o);
  a_r7_collision_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && valid_o && !take && !halt_q) |=> ovr_o);
  a_r8_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  a_r8_abort_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !dma_req_o);
  a_r8_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !ovr_clr_i) |=> $stable(data_o));
  a_r9_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store
  import adc_rs_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int OUT_W  = 16,
  parameter int CHAN_W = 5,
  parameter int N_INJ  = 4,
  localparam int IDX_W = $clog2(N_INJ)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   res_valid_i,
  input  logic                   res_inj_i,
  input  logic [IDX_W-1:0]       res_idx_i,
  input  logic [CHAN_W-1:0]      res_chan_i,
  input  logic [RAW_W-1:0]       res_data_i,
  input  logic [1:0]             cfg_res_i,
  input  logic                   cfg_left_i,
  input  logic                   cfg_dma_en_i,
  input  logic [N_INJ-1:0]       ofs_en_i,
  input  logic [N_INJ*RAW_W-1:0] ofs_val_i,
  input  logic                   reg_rd_i,
  input  logic                   dma_ack_i,
  input  logic                   ovr_clr_i,
  input  logic [N_INJ-1:0]       inj_rd_i,
  output logic [OUT_W-1:0]       reg_data_o,
  output logic [CHAN_W-1:0]      reg_chan_o,
  output logic                   reg_valid_o,
  output logic                   dma_req_o,
  output logic                   ovr_o,
  output logic                   abort_o,
  output logic [N_INJ*OUT_W-1:0] inj_data_o,
  output logic [N_INJ-1:0]       inj_valid_o
);
  logic [OUT_W-1:0] reg_fmt;
  logic             reg_wr;

  assign reg_wr = res_valid_i & ~res_inj_i;

  adc_rs_fmt #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_reg_fmt (
    .raw_i    (res_data_i),
    .ofs_i    ('0),
    .res_i    (cfg_res_i),
    .left_i   (cfg_left_i),
    .signed_i (1'b0),
    .data_o   (reg_fmt)
  );

  adc_rs_regular #(.OUT_W(OUT_W), .CHAN_W(CHAN_W)) u_regular (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr),
    .data_i    (reg_fmt),
    .chan_i    (res_chan_i),
    .rd_i      (reg_rd_i),
    .ack_i     (dma_ack_i),
    .dma_en_i  (cfg_dma_en_i),
    .ovr_clr_i (ovr_clr_i),
    .data_o    (reg_data_o),
    .chan_o    (reg_chan_o),
    .valid_o   (reg_valid_o),
    .dma_req_o (dma_req_o),
    .ovr_o     (ovr_o),
    .abort_o   (abort_o)
  );

  for (genvar j = 0; j < N_INJ; j++) begin : g_slot
    logic [OUT_W-1:0] fmt;
    logic             wr;

    assign wr = res_valid_i & res_inj_i & (res_idx_i == IDX_W'(j));

    adc_rs_fmt #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_fmt (
      .raw_i    (res_data_i),
      .ofs_i    (ofs_val_i[j*RAW_W +: RAW_W]),
      .res_i    (cfg_res_i),
      .left_i   (cfg_left_i),
      .signed_i (ofs_en_i[j]),
      .data_o   (fmt)
    );

    adc_rs_inj_slot #(.OUT_W(OUT_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr),
      .rd_i    (inj_rd_i[j]),
      .data_i  (fmt),
      .valid_o (inj_valid_o[j]),
      .data_o  (inj_data_o[j*OUT_W +: OUT_W])
    );
  end

  // R10: injected traffic leaves the regular side alone
  a_r10_inj_no_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_inj_i && !ovr_o) |=> !ovr_o);
  a_r10_inj_keeps_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_inj_i) |=> $stable(reg_data_o));
endmodule

// File: tb/adc_result_store_tb.sv
module adc_result_store_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        res_valid = 0, res_inj = 0;
  logic [1:0]  res_idx = 0;
  logic [4:0]  res_chan = 0;
  logic [11:0] res_data = 0;
  logic [1:0]  cfg_res = 0;
  logic        cfg_left = 0, cfg_dma = 0;
  logic [3:0]  ofs_en = 0;
  logic [47:0] ofs_val = 0;
  logic        reg_rd = 0, dma_ack = 0, ovr_clr = 0;
  logic [3:0]  inj_rd = 0;
  logic [15:0] reg_data;
  logic [4:0]  reg_chan;
  logic        reg_valid, dma_req, ovr, abort_p;
  logic [63:0] inj_data;
  logic [3:0]  inj_valid;

  adc_result_store u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .res_valid_i(res_valid), .res_inj_i(res_inj), .res_idx_i(res_idx),
    .res_chan_i(res_chan), .res_data_i(res_data),
    .cfg_res_i(cfg_res), .cfg_left_i(cfg_left), .cfg_dma_en_i(cfg_dma),
    .ofs_en_i(ofs_en), .ofs_val_i(ofs_val),
    .reg_rd_i(reg_rd), .dma_ack_i(dma_ack), .ovr_clr_i(ovr_clr), .inj_rd_i(inj_rd),
    .reg_data_o(reg_data), .reg_chan_o(reg_chan), .reg_valid_o(reg_valid),
    .dma_req_o(dma_req), .ovr_o(ovr), .abort_o(abort_p),
    .inj_data_o(inj_data), .inj_valid_o(inj_valid)
  );

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard
  int          due_q[$];
  string       req_q[$];
  int          sig_q[$];
  logic [15:0] exp_q[$];

  localparam int S_DATA = 0, S_VALID = 1, S_OVR = 2, S_REQ = 3, S_ABORT = 4,
                 S_IMASK = 5, S_INJ0 = 6, S_CHAN = 10;

  function automatic logic [15:0] sample(int s);
    case (s)
      S_DATA:  return reg_data;
      S_VALID: return {15'd0, reg_valid};
      S_OVR:   return {15'd0, ovr};
      S_REQ:   return {15'd0, dma_req};
      S_ABORT: return {15'd0, abort_p};
      S_IMASK: return {12'd0, inj_valid};
      S_CHAN:  return {11'd0, reg_chan};
      default: return inj_data[(s-S_INJ0)*16 +: 16];
    endcase
  endfunction

  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      automatic string r = req_q.pop_front();
      automatic int s = sig_q.pop_front();
      automatic logic [15:0] e = exp_q.pop_front();
      automatic logic [15:0] g = sample(s);
      void'(due_q.pop_front());
      n_chk++;
      if (g !== e) begin
        n_bad++;
        $display("FAIL %s sig %0d: got %h expected %h (cycle %0d)", r, s, g, e, cyc);
      end
    end
  end

  task automatic expect_v(string r, int s, logic [15:0] e);
    due_q.push_back(cyc + 1); req_q.push_back(r); sig_q.push_back(s); exp_q.push_back(e);
  endtask

  // model of the formatting requirements (R3, R4, R11, R12)
  function automatic logic [15:0] model(int code, bit left, bit sgn, int raw, int ofs);
    int k = 12 - 2 * code;
    int v = raw % (1 << k);
    int d;
    if (!sgn) return 16'(left ? v * (1 << (16 - k)) : v);
    d = v - (ofs % (1 << k));
    return 16'(left ? d * (1 << (15 - k)) : d);
  endfunction

  task automatic nx();
    @(negedge clk);
    res_valid = 0; res_inj = 0; reg_rd = 0; dma_ack = 0; ovr_clr = 0; inj_rd = 0;
  endtask

  task automatic beat(bit inj, int idx, int chan, int raw);
    res_valid = 1; res_inj = inj; res_idx = 2'(idx); res_chan = 5'(chan); res_data = 12'(raw);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_v("R1", S_VALID, 0); expect_v("R1", S_OVR, 0); expect_v("R1", S_REQ, 0);
    expect_v("R1", S_IMASK, 0); expect_v("R1", S_DATA, 0); expect_v("R1", S_ABORT, 0);
    nx();

    // R2 capture, R3/R4 formatting
    beat(0, 0, 5, 12'hABC);
    expect_v("R2", S_VALID, 1); expect_v("R2", S_DATA, 16'h0ABC); expect_v("R2", S_CHAN, 5);
    nx();
    reg_rd = 1; expect_v("R5", S_VALID, 0); nx();
    cfg_res = 2; cfg_left = 1; beat(0, 0, 3, 12'hF5A);
    expect_v("R4", S_DATA, model(2, 1, 0, 12'hF5A, 0)); expect_v("R3", S_CHAN, 3); nx();
    reg_rd = 1; nx();
    cfg_res = 3; cfg_left = 0; beat(0, 0, 1, 12'hFFF);
    expect_v("R3", S_DATA, 16'h003F); nx();
    reg_rd = 1; nx();
    cfg_res = 1; cfg_left = 1; beat(0, 0, 1, 12'hC01);
    expect_v("R3", S_DATA, model(1, 1, 0, 12'hC01, 0)); nx();
    reg_rd = 1; nx();

    // R7 / R9 overrun without DMA
    cfg_res = 0; cfg_left = 0;
    beat(0, 0, 2, 12'h111); nx();
    beat(0, 0, 2, 12'h222);
    expect_v("R7", S_OVR, 1); expect_v("R7", S_DATA, 16'h0222); expect_v("R7", S_VALID, 1); nx();
    expect_v("R9", S_OVR, 1); nx();
    beat(0, 0, 2, 12'h333); ovr_clr = 1;
    expect_v("R9", S_OVR, 1); expect_v("R7", S_DATA, 16'h0333); nx();
    ovr_clr = 1; expect_v("R9", S_OVR, 0); nx();
    reg_rd = 1; nx();

    // R5 read and new beat in the same cycle
    beat(0, 0, 4, 12'h444); nx();
    beat(0, 0, 4, 12'h555); reg_rd = 1;
    expect_v("R5", S_OVR, 0); expect_v("R5", S_DATA, 16'h0555); expect_v("R5", S_VALID, 1); nx();
    reg_rd = 1; nx();

    // R6 / R8 DMA draining and halt
    cfg_dma = 1;
    beat(0, 0, 6, 12'h0AA); expect_v("R6", S_REQ, 1); nx();
    dma_ack = 1; expect_v("R5", S_REQ, 0); expect_v("R5", S_VALID, 0); nx();
    beat(0, 0, 6, 12'h0BB); nx();
    beat(0, 0, 6, 12'h0CC);
    expect_v("R8", S_OVR, 1); expect_v("R8", S_ABORT, 1);
    expect_v("R8", S_DATA, 16'h00BB); expect_v("R8", S_REQ, 0); nx();
    beat(0, 0, 6, 12'h0DD);
    expect_v("R8", S_ABORT, 0); expect_v("R8", S_DATA, 16'h00BB);
    expect_v("R8", S_OVR, 1); expect_v("R8", S_REQ, 0); nx();
    ovr_clr = 1;
    expect_v("R8", S_OVR, 0); expect_v("R8", S_REQ, 1); expect_v("R8", S_DATA, 16'h00BB); nx();
    dma_ack = 1; nx();
    cfg_dma = 0;

    // R10 / R11 / R12 injected slots
    ofs_en = 4'b1010; ofs_val[12 +: 12] = 12'h100; ofs_val[36 +: 12] = 12'h03F;
    beat(1, 1, 0, 12'h080);
    expect_v("R11", S_INJ0 + 1, 16'hFF80); expect_v("R10", S_IMASK, 4'b0010);
    expect_v("R10", S_VALID, 0); nx();
    beat(1, 0, 0, 12'h123);
    expect_v("R10", S_INJ0, 16'h0123); expect_v("R10", S_IMASK, 4'b0011); nx();
    inj_rd = 4'b0010; expect_v("R10", S_IMASK, 4'b0001); nx();
    cfg_left = 1; beat(1, 1, 0, 12'h080);
    expect_v("R12", S_INJ0 + 1, 16'hFC00); nx();
    beat(1, 2, 0, 12'h800);
    expect_v("R12", S_INJ0 + 2, 16'h8000); nx();
    cfg_res = 3; beat(1, 3, 0, 12'h000);
    expect_v("R12", S_INJ0 + 3, model(3, 1, 1, 0, 12'h03F)); nx();
    cfg_res = 2; cfg_left = 0; beat(1, 1, 0, 12'h0F5);
    expect_v("R11", S_INJ0 + 1, 16'h00F5); nx();
    cfg_res = 0;
    beat(0, 0, 7, 12'h777); nx();
    beat(1, 0, 0, 12'h001);
    expect_v("R10", S_OVR, 0); expect_v("R10", S_DATA, 16'h0777);
    expect_v("R10", S_INJ0, 16'h0001); nx();
    reg_rd = 1; nx();
    nx(); nx();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule